// File: doc/BRIEF.md
# Timer Compare Channel Output Generator

This block is a single compare channel of a general-purpose timer. A 16-bit counter steps up or down between zero and a programmable reload limit while the timer enable is high. Each tick compares the counter with an active compare value. A 3-bit output-mode selector turns the result into one reference level. The selector can hold the level, clear it, set it, toggle it, force it low or high, or produce one of two complementary pulse-width patterns.

Software-side configuration goes through one write port. A 2-bit selector picks the target register: the reload limit, the compare value, the output mode, or a control word. The control word holds the compare preload enable and the count direction. With preload off, compare writes land at once. With preload on, they wait in a shadow copy until the next counter wrap. The block also gives a one-cycle update pulse at every wrap and a one-cycle match pulse at every tick that hits the compare value.

Top module: `tmr_cmp_chan`

## Requirements
- R1: With `rst` high at a clock edge, `oref`, `upd_evt` and `match_pls` are 0 after that edge. Reset also sets the counter and compare value to 0, the reload limit to all ones, the mode to 0, preload off and the direction to up.
- R2: While `tmr_en` is high, each clock is one tick. Counting up, the counter advances until it is at or above the reload limit, then returns to 0. Counting down, it decrements until it reaches 0, then loads the reload limit. `upd_evt` is high for the cycle that follows each such wrap tick. While `tmr_en` is low, the counter holds and `upd_evt` stays 0.
- R3: `match_pls` is high for the cycle after each tick at which the counter equals the active compare value, and is 0 otherwise.
- R4: On a match tick, mode 0 leaves `oref` unchanged, mode 1 drives it to 0 and mode 2 drives it to 1. Without a match tick these modes do not change `oref`.
- R5: In mode 3, `oref` inverts at every match tick.
- R6: Mode 4 drives `oref` to 0 and mode 5 drives it to 1 at every clock edge, whatever the counter, the compare value or `tmr_en`.
- R7: At every clock edge, mode 6 sets `oref` to 1 when the counter is below the active compare value and to 0 otherwise, in both count directions. Mode 7 sets the inverse level. The counter is sampled before that edge's tick.
- R8: With preload off, a compare write (`wr_sel`=1) becomes the active compare value at the clock edge that accepts it, in the middle of a period, with no update event.
- R9: With preload on, a compare write goes only to a shadow value. The shadow value becomes active at the next wrap tick. A write accepted at the wrap tick itself becomes active at that tick.
- R10: Register encoding: `wr_sel`=0 is the reload limit, 1 is the compare value, 2 is the mode in `wr_data[2:0]`, and 3 is control, with bit 0 as preload enable and bit 1 as count down. A new mode or control word first governs the tick after the edge that writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Timer enable; each clock is a tick while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 reload, 1 compare, 2 mode, 3 control) |
| wr_data | input | 16 | Write data |
| oref | output | 1 | Channel reference level |
| upd_evt | output | 1 | One-cycle pulse after each counter wrap |
| match_pls | output | 1 | One-cycle pulse after each compare hit |

## Verification
The hardest case is a preloaded compare write that arrives in the same cycle as a counter wrap. In that cycle the shadow copy and the shadow-to-active transfer both want to act. The bench provokes this by writing a new compare value on every cycle across whole periods with preload on. It judges the result by the position of each match pulse and pulse-width edge, which a cycle-level reference model in the bench predicts from the written value. A second pair is a match tick and a wrap tick landing together when the compare value equals the reload limit or zero. Here the bench checks that `match_pls` and `upd_evt` both assert in the same cycle.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        OM_HOLD = 3'd0,
        OM_CLR  = 3'd1,
        OM_SET  = 3'd2,
        OM_TGL  = 3'd3,
        OM_FLO  = 3'd4,
        OM_FHI  = 3'd5,
        OM_PWM1 = 3'd6,
        OM_PWM2 = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SEL_RLD  = 2'd0,
        SEL_CMP  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef struct packed {
        logic down;
        logic preload;
    } ctrl_t;

    localparam int CTRL_PRE_BIT  = 0;
    localparam int CTRL_DOWN_BIT = 1;

    // Level produced by the two pulse-width modes.
    function automatic logic pwm_level(input logic below, input mode_e m);
        return (m == OM_PWM2) ? ~below : below;
    endfunction

endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         down,
    input  logic [W-1:0] rld,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         upd_evt
);
    logic [W-1:0] cnt_q;

    always_comb begin
        if (down) wrap = en && (cnt_q == '0);
        else      wrap = en && (cnt_q >= rld);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            upd_evt <= 1'b0;
        end else begin
            upd_evt <= wrap;
            if (en) begin
                if (wrap)      cnt_q <= down ? rld : '0;
                else if (down) cnt_q <= cnt_q - 1'b1;
                else           cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tcc_cmpreg.sv
module tcc_cmpreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_cmp,
    input  logic [W-1:0] wr_data,
    input  logic         preload,
    input  logic         wrap,
    output logic [W-1:0] cmp_act
);
    logic [W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            cmp_act  <= '0;
        end else begin
            if (wr_cmp) shadow_q <= wr_data;
            if (!preload) begin
                if (wr_cmp) cmp_act <= wr_data;
            end else if (wrap) begin
                cmp_act <= wr_cmp ? wr_data : shadow_q;
            end
        end
    end
endmodule

// File: rtl/tcc_refgen.sv
module tcc_refgen
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  mode_e        mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_act,
    output logic         oref,
    output logic         match_pls
);
    logic hit;
    logic below;
    logic oref_d;

    assign hit   = en && (cnt == cmp_act);
    assign below = (cnt < cmp_act);

    always_comb begin
        oref_d = oref;
        unique case (mode)
            OM_HOLD:          oref_d = oref;
            OM_CLR:           if (hit) oref_d = 1'b0;
            OM_SET:           if (hit) oref_d = 1'b1;
            OM_TGL:           if (hit) oref_d = ~oref;
            OM_FLO:           oref_d = 1'b0;
            OM_FHI:           oref_d = 1'b1;
            OM_PWM1, OM_PWM2: oref_d = pwm_level(below, mode);
            default:          oref_d = oref;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oref      <= 1'b0;
            match_pls <= 1'b0;
        end else begin
            oref      <= oref_d;
            match_pls <= hit;
        end
    end
endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             oref,
    output logic             upd_evt,
    output logic             match_pls
);
    localparam logic [CNT_W-1:0] RLD_RST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] rld_q;
    mode_e            mode_q;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_act;
    logic             wrap;
    logic             wr_cmp;
    sel_e             sel;

    assign sel    = sel_e'(wr_sel);
    assign wr_cmp = wr_en && (sel == SEL_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q  <= RLD_RST;
            mode_q <= OM_HOLD;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_RLD:  rld_q  <= wr_data;
                SEL_MODE: mode_q <= mode_e'(wr_data[2:0]);
                SEL_CTRL: begin
                    ctrl_q.preload <= wr_data[CTRL_PRE_BIT];
                    ctrl_q.down    <= wr_data[CTRL_DOWN_BIT];
                end
                default: ;
            endcase
        end
    end

    tcc_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (tmr_en),
        .down    (ctrl_q.down),
        .rld     (rld_q),
        .cnt     (cnt),
        .wrap    (wrap),
        .upd_evt (upd_evt)
    );

    tcc_cmpreg #(.W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_cmp  (wr_cmp),
        .wr_data (wr_data),
        .preload (ctrl_q.preload),
        .wrap    (wrap),
        .cmp_act (cmp_act)
    );

    tcc_refgen #(.W(CNT_W)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .en        (tmr_en),
        .mode      (mode_q),
        .cnt       (cnt),
        .cmp_act   (cmp_act),
        .oref      (oref),
        .match_pls (match_pls)
    );
endmodule

// File: rtl/tcc_chk.sv
module tcc_chk
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tmr_en,
    input mode_e        mode_q,
    input logic         pre_q,
    input logic         wrap,
    input logic [W-1:0] cmp_act,
    input logic         oref,
    input logic         upd_evt,
    input logic         match_pls
);
    // R6
    force_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OM_FLO) |=> !oref);

    // R6
    force_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == OM_FHI) |=> oref);

    // R2
    upd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |=> !upd_evt);

    // R3
    match_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |=> !match_pls);

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_q && !wrap) |=> $stable(cmp_act));
endmodule

bind tmr_cmp_chan tcc_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmr_en    (tmr_en),
    .mode_q    (mode_q),
    .pre_q     (ctrl_q.preload),
    .wrap      (wrap),
    .cmp_act   (cmp_act),
    .oref      (oref),
    .upd_evt   (upd_evt),
    .match_pls (match_pls)
);

// File: tb/tmr_cmp_chan_tb.sv
module tmr_cmp_chan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tmr_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         oref, upd_evt, match_pls;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    string       phase = "R1";
    bit          done = 1'b0;

    typedef struct {
        logic  oref;
        logic  upd;
        logic  mat;
        logic  [2:0] mode;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cmp_chan #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .tmr_en(tmr_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .oref(oref), .upd_evt(upd_evt), .match_pls(match_pls)
    );

    // Reference model built from the requirements.
    logic [W-1:0] m_cnt, m_rld, m_cmp, m_sh;
    logic [2:0]   m_mode;
    logic         m_pre, m_down, m_oref;

    always @(posedge clk) begin
        exp_t e;
        logic hit, wr, wc;
        if (rst) begin
            m_cnt = '0; m_rld = '1; m_cmp = '0; m_sh = '0;
            m_mode = 3'd0; m_pre = 1'b0; m_down = 1'b0; m_oref = 1'b0;
            e.oref = 1'b0; e.upd = 1'b0; e.mat = 1'b0;
        end else begin
            hit = tmr_en && (m_cnt == m_cmp);
            wr  = tmr_en && (m_down ? (m_cnt == '0) : (m_cnt >= m_rld));
            wc  = wr_en && (wr_sel == 2'd1);
            case (m_mode)
                3'd1: if (hit) m_oref = 1'b0;
                3'd2: if (hit) m_oref = 1'b1;
                3'd3: if (hit) m_oref = ~m_oref;
                3'd4: m_oref = 1'b0;
                3'd5: m_oref = 1'b1;
                3'd6: m_oref = (m_cnt < m_cmp);
                3'd7: m_oref = !(m_cnt < m_cmp);
                default: ;
            endcase
            e.oref = m_oref; e.upd = wr; e.mat = hit;
            if (tmr_en) begin
                if (wr)          m_cnt = m_down ? m_rld : '0;
                else if (m_down) m_cnt = m_cnt - 1'b1;
                else             m_cnt = m_cnt + 1'b1;
            end
            if (!m_pre) begin
                if (wc) m_cmp = wr_data;
            end else if (wr) begin
                m_cmp = wc ? wr_data : m_sh;
            end
            if (wc) m_sh = wr_data;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_rld = wr_data;
                    2'd2: m_mode = wr_data[2:0];
                    2'd3: begin m_pre = wr_data[0]; m_down = wr_data[1]; end
                    default: ;
                endcase
            end
        end
        e.mode = m_mode;
        e.tag = phase;
        exp_q.push_back(e);
    end

    task automatic cmp1(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Monitor: compares outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            exp_t e;
            e = exp_q.pop_front();
            cmp1($sformatf("[%s] oref mode%0d", e.tag, e.mode), oref, e.oref);
            cmp1($sformatf("[%s] upd_evt R2", e.tag), upd_evt, e.upd);
            cmp1($sformatf("[%s] match_pls R3", e.tag), match_pls, e.mat);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wreg(input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        phase = "R1";
        idle(3);
        @(negedge clk); rst = 1'b0;

        // R2: up then down counting with wrap pulses, then hold
        phase = "R2";
        wreg(2'd0, 16'd9);
        wreg(2'd1, 16'd9);
        tmr_en = 1'b1;
        idle(25);
        wreg(2'd3, 16'h0002);
        idle(25);
        tmr_en = 1'b0;
        idle(6);
        tmr_en = 1'b1;
        wreg(2'd1, 16'd0);
        idle(22);
        wreg(2'd3, 16'h0000);

        // R3 and R4: match pulses with hold, clear, set
        phase = "R4";
        wreg(2'd1, 16'd3);
        wreg(2'd2, 16'd2); idle(14);
        wreg(2'd2, 16'd0); idle(14);
        wreg(2'd2, 16'd1); idle(14);
        wreg(2'd2, 16'd0); idle(8);

        // R5: toggle in both directions
        phase = "R5";
        wreg(2'd2, 16'd3); idle(25);
        wreg(2'd3, 16'h0002); idle(25);
        wreg(2'd3, 16'h0000);

        // R6: force modes with the timer off and on
        phase = "R6";
        tmr_en = 1'b0;
        wreg(2'd2, 16'd5); idle(4);
        wreg(2'd2, 16'd4); idle(4);
        tmr_en = 1'b1;
        wreg(2'd2, 16'd5); idle(12);

        // R7: pulse-width modes, edge compare values, both directions
        phase = "R7";
        wreg(2'd1, 16'd4);
        wreg(2'd2, 16'd6); idle(22);
        wreg(2'd2, 16'd7); idle(22);
        wreg(2'd3, 16'h0002); idle(22);
        wreg(2'd2, 16'd6); idle(22);
        wreg(2'd1, 16'd0); idle(12);
        wreg(2'd1, 16'd10); idle(12);
        wreg(2'd3, 16'h0000);

        // R8: immediate compare writes mid-period
        phase = "R8";
        wreg(2'd2, 16'd3);
        wreg(2'd1, 16'd6); idle(3);
        wreg(2'd1, 16'd2); idle(5);
        wreg(2'd2, 16'd6); idle(3);
        wreg(2'd1, 16'd8); idle(12);

        // R9: preloaded writes, including writes on the wrap tick
        phase = "R9";
        wreg(2'd3, 16'h0001);
        wreg(2'd1, 16'd2); idle(15);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'((k * 3) % 11);
        end
        @(negedge clk); wr_en = 1'b0;
        idle(12);
        wreg(2'd3, 16'h0003); idle(4);
        wreg(2'd1, 16'd7); idle(24);

        // R10: mode and control changes on back-to-back cycles
        phase = "R10";
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 16'd5;
        @(negedge clk); wr_data = 16'd4;
        @(negedge clk); wr_data = 16'd7;
        @(negedge clk); wr_sel = 2'd3; wr_data = 16'h0000;
        @(negedge clk); wr_sel = 2'd2; wr_data = 16'd3;
        @(negedge clk); wr_en = 1'b0;
        idle(20);

        // R1: reset in the middle of activity
        phase = "R1";
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0; tmr_en = 1'b0;
        idle(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule